// File: doc/BRIEF.md
# Gated BCD Frequency Meter Core

The block measures how often an external pulse signal rises. A gate opens for a programmable number of system-clock cycles, nominally one second. While the gate is open, every counted rising edge advances a chain of decimal digits. When the gate closes, the digits are copied into an output register and then zeroed. The next gate opens only after an equal idle interval, so each measurement takes two gate lengths. Because the output register is written only once per measurement, a display driven from it never shows a partial count.

The measured input is asynchronous. It is synchronized into the system clock domain and reduced to one-cycle edge pulses, so every register in the block runs on the system clock. A two-bit range input places a divider in front of the digit chain, so high input rates can be brought into range. The result is packed BCD. A one-cycle strobe marks each new result, and an overflow flag is stored together with the result.

Top module: `freq_meter`

## Requirements
- R1: The gate is open for GATE_CYCLES clock cycles and then closed for GATE_CYCLES cycles, repeating from reset. Consecutive `valid_o` pulses are therefore exactly 2*GATE_CYCLES cycles apart.
- R2: Edges that arrive while the gate is closed are ignored, and the digit chain holds its value.
- R3: After the gate closes, the digits are copied into the output register. `bcd_o` and `ovf_o` change only on that copy. `valid_o` is high for exactly the one cycle in which the new value first appears.
- R4: The digit chain and the range divider are zeroed in the cycle after the copy, before the next gate opens. An edge counted in the last open cycle is still included in the copied result.
- R5: Each digit counts 0 to 9 and then returns to 0. It passes a carry to the next digit only when it rolls over from 9.
- R6: The result is packed as 4-bit BCD digits, with the least significant digit in bits 3:0 and each higher digit in the next nibble up.
- R7: `range_i` selects the counted signal. 00 counts every edge, 01 counts one per 5 edges, 10 one per 10 edges, and 11 one per 50 edges. The reported value is floor(edges in gate / divisor).
- R8: `sig_i` may change at any time. Each rising edge that holds high and low for at least one clock period is counted exactly once.
- R9: If the count exceeds the largest value the digits can hold, the digits wrap. `ovf_o` is then reported high with that result and low again for the next result that does not overflow.
- R10: During and after reset, `bcd_o` is 0, `valid_o` is 0 and `ovf_o` is 0, until the first copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Asynchronous signal being measured |
| range_i | input | 2 | Input divider select (1, 5, 10, 50) |
| bcd_o | output | 4*DIGITS (32) | Latched packed BCD result |
| valid_o | output | 1 | One-cycle strobe on each new result |
| ovf_o | output | 1 | Overflow flag stored with the result |

## Verification
Two events can land in the same cycle, and the bench aims stimulus at both. First, a synchronized edge can arrive in the last open gate cycle, one cycle before the copy. Second, an edge can arrive in the same cycle as the clear. The bench times one pulse so that its edge falls on the last open cycle, and the expected result includes that pulse. It times a second pulse so that its edge falls on the clear cycle, and more pulses follow through the idle interval. All of those must be absent from the next result, which is expected to be zero. A scoreboard compares each result with floor(edges/divisor) wrapped to the digit count. It also checks that the output never moved between strobes.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    RANGE_X1  = 2'b00,
    RANGE_D5  = 2'b01,
    RANGE_D10 = 2'b10,
    RANGE_D50 = 2'b11
  } range_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R8: a single edge yields a single pulse
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fm_prescale.sv
module fm_prescale import fm_pkg::*; #(
  parameter int unsigned DIV_A = 5,
  parameter int unsigned DIV_B = 10,
  parameter int unsigned DIV_C = 50
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pulse_i,
  input  logic   en_i,
  input  logic   clr_i,
  input  range_e range_i,
  output logic   pulse_o
);
  localparam int unsigned MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int unsigned CW     = $clog2(MAX_D);

  logic       step;
  logic [2:0] tick;

  assign step = pulse_i & en_i;

  for (genvar g = 0; g < 3; g++) begin : g_div
    localparam int unsigned DV = (g == 0) ? DIV_A : (g == 1) ? DIV_B : DIV_C;
    localparam logic [CW-1:0] TOP = CW'(DV - 1);
    logic [CW-1:0] cnt_q;

    assign tick[g] = step & (cnt_q == TOP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (step)  cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    pulse_o = 1'b0;
    case (range_i)
      RANGE_X1:  pulse_o = step;
      RANGE_D5:  pulse_o = tick[0];
      RANGE_D10: pulse_o = tick[1];
      RANGE_D50: pulse_o = tick[2];
    endcase
  end

  // R7: a divided range never emits back-to-back pulses
  assert_div_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && range_i != RANGE_X1) |=> !(pulse_o && $stable(range_i)));
endmodule

// File: rtl/fm_gate_ctrl.sv
module fm_gate_ctrl #(
  parameter int unsigned GATE_CYCLES = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_o,
  output logic latch_o,
  output logic clear_o
);
  localparam int unsigned PERIOD = 2 * GATE_CYCLES;
  localparam int unsigned CW     = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] SHUT = CW'(GATE_CYCLES);
  localparam logic [CW-1:0] WIPE = CW'(GATE_CYCLES + 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign gate_o  = phase_q < SHUT;
  assign latch_o = phase_q == SHUT;
  assign clear_o = phase_q == WIPE;

  // R3: copy happens in the first closed cycle
  assert_latch_on_close_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> latch_o);
  // R4: clear directly follows the copy
  assert_clear_after_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> clear_o);
  // R2: copy and clear never overlap an open gate
  assert_closed_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o || clear_o) |-> !gate_o);
endmodule

// File: rtl/fm_bcd_chain.sv
module fm_bcd_chain import fm_pkg::*; #(
  parameter int unsigned DIGITS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    inc_i,
  input  logic                    clr_i,
  output logic [NIB_W*DIGITS-1:0] digits_o,
  output logic                    ovf_o
);
  logic [DIGITS:0] carry;
  logic            ovf_q;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [NIB_W-1:0] dig_q;
    logic             at_nine;

    assign at_nine      = dig_q == NIB_W'(9);
    assign carry[i+1]   = carry[i] & at_nine;
    assign digits_o[NIB_W*i +: NIB_W] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;
      else if (carry[i]) dig_q <= at_nine ? '0 : dig_q + 1'b1;
    end

    // R5: every digit stays decimal
    assert_digit_decimal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dig_q <= NIB_W'(9));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ovf_q <= 1'b0;
    else if (clr_i)        ovf_q <= 1'b0;
    else if (carry[DIGITS]) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  // R2: without an increment or clear the chain holds
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(digits_o));
  // R9: overflow stays set until cleared
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
endmodule

// File: rtl/freq_meter.sv
module freq_meter import fm_pkg::*; #(
  parameter int unsigned GATE_CYCLES = 50_000_000,
  parameter int unsigned DIGITS      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A       = 5,
  parameter int unsigned DIV_B       = 10,
  parameter int unsigned DIV_C       = 50
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sig_i,
  input  logic [1:0]              range_i,
  output logic [NIB_W*DIGITS-1:0] bcd_o,
  output logic                    valid_o,
  output logic                    ovf_o
);
  localparam int unsigned RES_W = NIB_W * DIGITS;

  logic             edge_p, count_p;
  logic             gate, latch, clear;
  logic [RES_W-1:0] run_digits;
  logic             run_ovf;
  logic [RES_W-1:0] bcd_q;
  logic             ovf_q, valid_q;

  fm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i), .rise_o(edge_p)
  );

  fm_gate_ctrl #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .gate_o(gate), .latch_o(latch), .clear_o(clear)
  );

  fm_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(edge_p), .en_i(gate),
    .clr_i(clear), .range_i(range_e'(range_i)), .pulse_o(count_p)
  );

  fm_bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(count_p), .clr_i(clear),
    .digits_o(run_digits), .ovf_o(run_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= latch;
      if (latch) begin
        bcd_q <= run_digits;
        ovf_q <= run_ovf;
      end
    end
  end

  assign bcd_o   = bcd_q;
  assign ovf_o   = ovf_q;
  assign valid_o = valid_q;

  // R3: output moves only together with the strobe
  assert_bcd_moves_on_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bcd_o) |-> valid_o);
  assert_valid_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R2: nothing is counted outside the gate
  assert_no_count_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_p |-> gate);
endmodule

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
  localparam int G  = 3000;
  localparam int D  = 3;
  localparam int BW = 4 * D;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sig = 1'b0;
  logic [1:0]    rng = 2'b00;
  logic [BW-1:0] bcd;
  logic          valid, ovf;

  always #10 clk = ~clk;

  freq_meter #(.GATE_CYCLES(G), .DIGITS(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig), .range_i(rng),
    .bcd_o(bcd), .valid_o(valid), .ovf_o(ovf)
  );

  int         checks = 0, errors = 0;
  logic [BW:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW:0] expect_word(input int edges, input int div);
    int q = edges / div;
    int lim = 1;
    logic [BW:0] w = '0;
    for (int i = 0; i < D; i++) lim *= 10;
    w[BW] = (q >= lim);
    q = q % lim;
    for (int i = 0; i < D; i++) begin
      w[4*i +: 4] = 4'(q % 10);
      q = q / 10;
    end
    return w;
  endfunction

  function automatic int div_of(input int r);
    case (r)
      0: return 1;
      1: return 5;
      2: return 10;
      default: return 50;
    endcase
  endfunction

  // scoreboard monitor
  int            cyc = 0, last_valid = -1;
  bit            moved = 1'b0, want_drop = 1'b0;
  logic [BW-1:0] prev_bcd = '0;
  always @(negedge clk) if (rst_ni && !done) begin
    cyc++;
    if (want_drop) begin
      chk(!valid, "R3 valid one cycle", valid, 0);
      want_drop = 1'b0;
    end
    if (valid) begin
      logic [BW:0] e;
      string t;
      chk(!moved, "R3 output stable between strobes", moved, 0);
      if (last_valid >= 0) chk(cyc - last_valid == 2 * G, "R1 result period", cyc - last_valid, 2 * G);
      last_valid = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected result", bcd, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bcd == e[BW-1:0], t, bcd, e[BW-1:0]);
        chk(ovf == e[BW], {t, " ovf R9"}, ovf, e[BW]);
      end
      moved = 1'b0;
      want_drop = 1'b1;
    end else if (bcd != prev_bcd) begin
      moved = 1'b1;
    end
    prev_bcd = bcd;
  end

  // one full measurement, starting at the negedge that shows valid
  task automatic do_window(input int r, input int n, input bit tail, input bit lead, input string tag);
    exp_q.push_back(expect_word(n + (tail ? 1 : 0), div_of(r)));
    tag_q.push_back(tag);
    for (int c = 0; c < 2 * G; c++) begin
      if (c == 5) rng = 2'(r);
      if (lead && c < 40)                         sig = (c % 2 == 0);
      else if (c >= G + 4 && c < G + 4 + 2 * n)   sig = ((c - G - 4) % 2 == 0);
      else if (tail && (c == 2*G-4 || c == 2*G-2)) sig = 1'b1;
      else                                         sig = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    exp_q.push_back(expect_word(0, 1));
    tag_q.push_back("R10 first result zero");
    repeat (4) @(negedge clk);
    chk(bcd == '0 && !valid && !ovf, "R10 reset state", {valid, ovf, bcd}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bcd == '0 && !valid && !ovf, "R10 after reset", {valid, ovf, bcd}, 0);
    while (!valid) @(negedge clk);
    do_window(0, 7,    0, 0, "R8 sparse edges");
    do_window(0, 123,  0, 0, "R5 R6 carry and packing");
    do_window(0, 999,  0, 0, "R5 full scale");
    do_window(0, 1005, 0, 0, "R9 wrap");
    do_window(1, 123,  0, 0, "R7 div5");
    do_window(2, 109,  0, 0, "R7 div10");
    do_window(3, 999,  0, 0, "R7 div50");
    do_window(0, 40,   1, 0, "R4 edge in last open cycle");
    do_window(0, 0,    0, 1, "R2 closed-gate edges ignored R4");
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule